// File: doc/BRIEF.md
# Counting Semaphore Cell with Wait and Try Views

This block is one storage cell of an inter-thread synchronisation unit, set up as a counting semaphore. Each access presents a three-bit view code, a read or write strobe, write data and the ID of the requesting thread. Reading through one of the two semaphore views acquires the semaphore: the count as it stood before the access comes back, and the count drops by one when it was above zero. Writing through either semaphore view releases it: the count rises by one and stops at the top of its range.

In the waiting view, an acquire on a zero count does not complete. The requester gets a stall response and its ID is recorded in a blocked-thread mask. The next release sends the whole mask out on a one-cycle wake vector and clears the mask. Each woken thread is expected to retry its acquire. In the try view, an acquire on zero returns zero and never stalls.

A raw view reads the count without changing it. A tag view holds three flag bits that software can write and read back. The FIFO-style views, and the codes that no view uses, are inert on this cell. All responses are registered and appear in the cycle after the access.

Top module: `semcell_top`

## Requirements
- R1: After reset the count, the tag bits and the blocked mask are zero, and rsp_valid, rsp_stall, rsp_data and wake_vec are all zero.
- R2: A read in view 4 (wait) or view 5 (try) on a nonzero count gives rsp_valid=1, rsp_stall=0 and rsp_data equal to the count before the access, one cycle later. The count then drops by one.
- R3: A read in view 4 on a zero count gives rsp_valid=1, rsp_stall=1 and rsp_data=0. The count stays zero and bit req_tid of the blocked mask is set.
- R4: A read in view 5 on a zero count gives rsp_data=0 and rsp_stall=0, and it leaves the blocked mask unchanged.
- R5: A write in view 4 or view 5 adds one to the count, except at 0xFFFF, where the count holds. The value of wr_data is ignored.
- R6: The cycle after a view 4 or 5 write, wake_vec equals the blocked mask as it was before that write, and the mask is cleared. In every other cycle wake_vec is zero.
- R7: A read in view 0 (raw) returns the count zero-extended and leaves it unchanged. A write in view 0 has no effect.
- R8: A write in view 1 (tag) stores wr_data[2:0]. A read in view 1 returns those three bits in rsp_data[2:0], with zeros above. Neither access changes the count.
- R9: Reads in views 2, 3, 6 and 7 return rsp_data=0 with rsp_stall=0. Writes in those views change neither the count nor the tag bits.
- R10: When rd_en and wr_en are both high, only the write is carried out, and rsp_valid stays 0 in the next cycle.
- R11: Stalled acquires from different threads add up in the blocked mask, so a single release wakes all of them together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| view_sel | input | 3 | View code of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data (used by the tag view only) |
| req_tid | input | log2(THREADS) | Requesting thread ID |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_stall | output | 1 | Read could not complete and the thread is now blocked |
| rsp_data | output | DATA_W | Read response data |
| wake_vec | output | THREADS | One-cycle pulse of the threads released by a write |

## Verification
A wrong count shows up on the very next acquire or raw read, because rsp_data carries the count from before the access. A wrong count can also show as a stall that should not happen, or as a missing stall. A wrong blocked mask is only visible on the next release, as a wrong wake_vec pulse one cycle after the write. For that reason the bench follows every blocking sequence with a release and with an idle cycle. The scoreboard predicts every output in every cycle, so a stray wake pulse or response is reported in the cycle where it appears.

// File: rtl/semcell_pkg.sv
package semcell_pkg;

  typedef enum logic [2:0] {
    VW_RAW     = 3'd0,
    VW_TAG     = 3'd1,
    VW_EF_WAIT = 3'd2,
    VW_EF_TRY  = 3'd3,
    VW_PV_WAIT = 3'd4,
    VW_PV_TRY  = 3'd5,
    VW_RSV6    = 3'd6,
    VW_RSV7    = 3'd7
  } view_e;

  typedef struct packed {
    logic rd_any;
    logic raw_rd;
    logic tag_rd;
    logic tag_wr;
    logic p_wait;
    logic p_try;
    logic v_inc;
  } op_t;

endpackage

// File: rtl/semcell_dec.sv
module semcell_dec
  import semcell_pkg::*;
(
  input  logic [2:0] view_sel,
  input  logic       rd_en,
  input  logic       wr_en,
  output op_t        op
);

  logic  rd_act;
  view_e vw;

  assign rd_act = rd_en && !wr_en;
  assign vw     = view_e'(view_sel);

  always_comb begin
    op        = '0;
    op.rd_any = rd_act;
    case (vw)
      VW_RAW: op.raw_rd = rd_act;
      VW_TAG: begin
        op.tag_rd = rd_act;
        op.tag_wr = wr_en;
      end
      VW_PV_WAIT: begin
        op.p_wait = rd_act;
        op.v_inc  = wr_en;
      end
      VW_PV_TRY: begin
        op.p_try = rd_act;
        op.v_inc = wr_en;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/semcell_counter.sv
module semcell_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             is_zero
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    end else if (dec) begin
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  assign cnt     = cnt_q;
  assign is_zero = (cnt_q == '0);

  // R5: the count stops at the top of its range
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R5: a release below the top adds one
  p_inc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_ONE);
  // R2: an acquire on a nonzero count takes one
  p_dec_step_r2: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_ONE);
  // R3: an acquire on zero leaves the count at zero
  p_zero_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt_q == '0) |=> cnt_q == '0);
  // R7: with no semaphore operation the count does not move
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec) |=> $stable(cnt_q));

endmodule

// File: rtl/semcell_waitlist.sv
module semcell_waitlist #(
  parameter int THREADS = 8,
  parameter int TID_W   = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               block,
  input  logic [TID_W-1:0]   tid,
  input  logic               release_all,
  output logic [THREADS-1:0] mask,
  output logic [THREADS-1:0] wake
);

  logic [THREADS-1:0] mask_q;
  logic [THREADS-1:0] wake_q;

  for (genvar g = 0; g < THREADS; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst)                                 mask_q[g] <= 1'b0;
      else if (release_all)                    mask_q[g] <= 1'b0;
      else if (block && tid == TID_W'(g))      mask_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              wake_q <= '0;
    else if (release_all) wake_q <= mask_q;
    else                  wake_q <= '0;
  end

  assign mask = mask_q;
  assign wake = wake_q;

  // R6: a release pulses out the prior mask and empties it
  p_wake_flush_r6: assert property (@(posedge clk) disable iff (rst)
    release_all |=> (wake_q == $past(mask_q)) && (mask_q == '0));
  // R6: no pulse without a release
  p_wake_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !release_all |=> wake_q == '0);
  // R3, R11: a blocked thread is recorded and earlier bits are kept
  p_block_set_r11: assert property (@(posedge clk) disable iff (rst)
    (block && !release_all) |=> ((mask_q & $past(mask_q)) == $past(mask_q))
                                && $countones(mask_q) >= $countones($past(mask_q)));

endmodule

// File: rtl/semcell_top.sv
module semcell_top
  import semcell_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int THREADS = 8,
  parameter int TAG_W   = 3,
  parameter int TID_W   = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         view_sel,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [TID_W-1:0]   req_tid,
  output logic               rsp_valid,
  output logic               rsp_stall,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [THREADS-1:0] wake_vec
);

  op_t                op;
  logic [CNT_W-1:0]   cnt;
  logic               cnt_zero;
  logic               block;
  logic [THREADS-1:0] blk_mask;
  logic [TAG_W-1:0]   tag_q;
  logic               valid_q;
  logic               stall_q;
  logic [DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]  data_n;

  semcell_dec u_dec (
    .view_sel (view_sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .op       (op)
  );

  semcell_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (op.v_inc),
    .dec     (op.p_wait || op.p_try),
    .cnt     (cnt),
    .is_zero (cnt_zero)
  );

  assign block = op.p_wait && cnt_zero;

  semcell_waitlist #(.THREADS(THREADS), .TID_W(TID_W)) u_wait (
    .clk         (clk),
    .rst         (rst),
    .block       (block),
    .tid         (req_tid),
    .release_all (op.v_inc),
    .mask        (blk_mask),
    .wake        (wake_vec)
  );

  always_ff @(posedge clk) begin
    if (rst)            tag_q <= '0;
    else if (op.tag_wr) tag_q <= wr_data[TAG_W-1:0];
  end

  always_comb begin
    data_n = '0;
    if (op.raw_rd)                              data_n = DATA_W'(cnt);
    else if (op.tag_rd)                         data_n = DATA_W'(tag_q);
    else if ((op.p_wait || op.p_try) && !cnt_zero) data_n = DATA_W'(cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      stall_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= op.rd_any;
      stall_q <= block;
      data_q  <= data_n;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_stall = stall_q;
  assign rsp_data  = data_q;

  // R3: a stall is a valid response carrying zero
  p_stall_shape_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_stall |-> (rsp_valid && rsp_data == '0));
  // R10: simultaneous strobes produce no read response
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |=> !rsp_valid);
  // R9: decoded operations are mutually exclusive
  p_op_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op.raw_rd, op.tag_rd, op.tag_wr, op.p_wait, op.p_try, op.v_inc}));
  // R8: tag bits move only on a tag write
  p_tag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !op.tag_wr |=> $stable(tag_q));

endmodule

// File: tb/test_semcell_top.sv
module test_semcell_top;

  localparam int DATA_W  = 32;
  localparam int THREADS = 8;
  localparam int TID_W   = 3;

  typedef struct {
    logic              v;
    logic              st;
    logic [DATA_W-1:0] d;
    logic [7:0]        w;
    string             req;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [2:0]         view_sel = '0;
  logic               rd_en = 1'b0;
  logic               wr_en = 1'b0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic [TID_W-1:0]   req_tid = '0;
  logic               rsp_valid;
  logic               rsp_stall;
  logic [DATA_W-1:0]  rsp_data;
  logic [THREADS-1:0] wake_vec;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  int unsigned m_cnt  = 0;
  logic [7:0]  m_mask = '0;
  logic [2:0]  m_tag  = '0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  semcell_top i_semcell_top (
    .clk       (clk),
    .rst       (rst),
    .view_sel  (view_sel),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .req_tid   (req_tid),
    .rsp_valid (rsp_valid),
    .rsp_stall (rsp_stall),
    .rsp_data  (rsp_data),
    .wake_vec  (wake_vec)
  );

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                     input string what, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(DATA_W'(rsp_valid), DATA_W'(e.v), "rsp_valid", e.req);
        chk(DATA_W'(rsp_stall), DATA_W'(e.st), "rsp_stall", e.req);
        chk(rsp_data, e.d, "rsp_data", e.req);
        chk(DATA_W'(wake_vec), DATA_W'(e.w), "wake_vec", e.req);
      end
    end
  end

  // driver: drive one access and push the predicted response
  task automatic acc(input logic [2:0] vw, input bit rd, input bit wr,
                     input logic [DATA_W-1:0] dat, input int tid, input string req);
    exp_t e;
    @(negedge clk);
    view_sel = vw; rd_en = rd; wr_en = wr; wr_data = dat; req_tid = TID_W'(tid);
    e.v = 1'b0; e.st = 1'b0; e.d = '0; e.w = '0; e.req = req;
    if (wr) begin
      if (vw == 3'd4 || vw == 3'd5) begin
        if (m_cnt < 32'hFFFF) m_cnt++;
        e.w = m_mask;
        m_mask = '0;
      end else if (vw == 3'd1) begin
        m_tag = dat[2:0];
      end
    end else if (rd) begin
      e.v = 1'b1;
      case (vw)
        3'd0: e.d = m_cnt;
        3'd1: e.d = DATA_W'(m_tag);
        3'd4: begin
          if (m_cnt > 0) begin e.d = m_cnt; m_cnt--; end
          else begin e.st = 1'b1; m_mask[tid] = 1'b1; end
        end
        3'd5: begin
          if (m_cnt > 0) begin e.d = m_cnt; m_cnt--; end
        end
        default: e.d = '0;
      endcase
    end
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs idle straight after reset
    #1;
    chk(DATA_W'(rsp_valid), 0, "rsp_valid after reset", "R1");
    chk(DATA_W'(wake_vec), 0, "wake_vec after reset", "R1");
    chk(rsp_data, 0, "rsp_data after reset", "R1");
    acc(3'd0, 1, 0, 0, 0, "R1");
    acc(3'd1, 1, 0, 0, 0, "R1");
    // R3, R4, R11: acquires on zero
    acc(3'd4, 1, 0, 0, 3, "R3");
    acc(3'd5, 1, 0, 0, 1, "R4");
    acc(3'd4, 1, 0, 0, 5, "R11");
    acc(3'd0, 1, 0, 0, 0, "R3");
    // R6: release wakes threads 3 and 5, data ignored (R5)
    acc(3'd4, 0, 1, 32'hDEADBEEF, 0, "R6");
    acc(3'd0, 0, 0, 0, 0, "R6");
    acc(3'd5, 0, 1, 32'h0, 2, "R5");
    acc(3'd0, 1, 0, 0, 0, "R5");
    // R2: acquire returns the prior count
    acc(3'd4, 1, 0, 0, 2, "R2");
    acc(3'd5, 1, 0, 0, 6, "R2");
    acc(3'd5, 1, 0, 0, 6, "R4");
    // R7: raw write ignored
    acc(3'd5, 0, 1, 0, 0, "R5");
    acc(3'd0, 0, 1, 32'h1234, 0, "R7");
    acc(3'd0, 1, 0, 0, 0, "R7");
    // R8: tag bits
    acc(3'd1, 0, 1, 32'hFFFF_FFF5, 0, "R8");
    acc(3'd1, 1, 0, 0, 0, "R8");
    acc(3'd0, 1, 0, 0, 0, "R8");
    // R9: inert views
    for (int v = 2; v < 8; v++) begin
      if (v == 4 || v == 5) continue;
      acc(3'(v), 1, 0, 0, 0, "R9");
      acc(3'(v), 0, 1, 32'h7, 0, "R9");
    end
    acc(3'd0, 1, 0, 0, 0, "R9");
    acc(3'd1, 1, 0, 0, 0, "R9");
    // R10: both strobes, write only
    acc(3'd4, 1, 1, 0, 0, "R10");
    acc(3'd0, 1, 0, 0, 0, "R10");
    // R5: saturation
    for (int i = 0; i < 65540; i++) acc(3'd5, 0, 1, 0, 0, "R5");
    acc(3'd0, 1, 0, 0, 0, "R5");
    acc(3'd5, 1, 0, 0, 0, "R2");
    acc(3'd0, 1, 0, 0, 0, "R2");
    acc(3'd0, 0, 0, 0, 0, "R6");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule